// File: doc/BRIEF.md
# Sliding-Surface Duty Regulator for a Step-Down Converter

This block closes the voltage loop of a voltage-mode step-down converter in the digital domain. A sample strobe arrives with a signed error word, formed upstream as target voltage minus measured output. From each such word the block keeps three state variables: the error itself, its saturating running sum, and its change since the previous sample. It weights them with three signed gains into a sliding-surface value S. It then moves an unsigned duty word by an arithmetically shifted copy of S, so that a positive error lengthens the high-side on-time and a negative error shortens it. The result is clamped into a programmable window.

The duty word feeds a counter-compare pulse-width stage. This stage stands in for the sawtooth comparator of the power stage, so the regulated duty can be seen as a gate signal. The compare register takes a new duty value only when the sawtooth wraps, so every switching period runs with a single, complete duty value. A typical operating point puts the duty near one quarter of full scale. At reset the duty word loads a programmable start value so the loop starts close to that point.

Top module: `smc_duty_ctrl`

## Requirements
- R1: While reset is held low, and on the first cycle after it rises, `duty` and `pwm_cmp` equal `duty_init`, `done` is low and `surf` is zero. The running sum and the stored previous error are cleared.
- R2: The error state equals `err_in` exactly. With cleared history and all-zero error, S is zero and the duty word keeps its value.
- R3: The running sum adds `err_in` once per strobe and saturates at the signed limits of an INT_W-bit word (-32768 and 32767 by default). It does not wrap.
- R4: The difference state is `err_in` minus the error of the previous strobe. The previous error is zero after reset.
- R5: `surf` = gain_p*error + gain_i*sum + gain_d*difference. The gains are signed with 8 fraction bits, and the sum already includes the current error. `surf` is valid when `done` is high.
- R6: The new duty word is the old one plus (S arithmetically shifted right by `shift_amt`). While the old duty lies inside the window, a positive S never lowers the duty and a negative S never raises it.
- R7: The sum is first raised to `duty_min` and then lowered to `duty_max`. If `duty_min` exceeds `duty_max`, the result is `duty_max`.
- R8: `done` is a one-cycle pulse. It goes high on the third rising edge counted from the edge that samples `sample_stb`, the same edge that updates `duty`. `duty` changes on no other edge.
- R9: Strobes on consecutive cycles are all accepted in order. Each one gives its own `done` pulse.
- R10: The sawtooth counter runs from 0 to 2^DUTY_W-1 and starts from 0 at reset. `gate_hi` is high while the count is below `pwm_cmp`, so each period of 2^DUTY_W clocks has exactly `pwm_cmp` high cycles.
- R11: `pwm_cmp` loads `duty` only on the edge that ends a cycle in which the count is at its maximum. The first period after reset uses `duty_init`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_stb | input | 1 | One new error sample this cycle |
| err_in | input | ERR_W (12) | Signed error, target minus measured |
| gain_p | input | GAIN_W (16) | Signed Q8 weight of the error state |
| gain_i | input | GAIN_W (16) | Signed Q8 weight of the running sum |
| gain_d | input | GAIN_W (16) | Signed Q8 weight of the difference state |
| shift_amt | input | SH_W (5) | Right shift applied to S before it moves the duty |
| duty_min | input | DUTY_W (8) | Lower duty clamp |
| duty_max | input | DUTY_W (8) | Upper duty clamp, wins over the lower one |
| duty_init | input | DUTY_W (8) | Duty and compare value loaded at reset |
| duty | output | DUTY_W (8) | Current duty word |
| pwm_cmp | output | DUTY_W (8) | Compare value used by the current switching period |
| gate_hi | output | 1 | High-side gate drive |
| done | output | 1 | Pulse marking a finished duty update |
| surf | output | INT_W+GAIN_W+2 (34) | Signed surface value of the last sample |

## Verification
The bench builds the block with its defaults: a 12-bit error, a 16-bit running sum, Q8 gains of 16 bits and an 8-bit duty. With these values a 256-clock switching period can be checked cycle by cycle. Both integrator limits are reached within about twenty full-scale strobes. A single unshifted proportional step of a large error drives the duty against each clamp. With a shift of 8 and a unit gain, the duty moves by exactly the error, so each direction check has a plain integer answer.

// File: rtl/smc_pkg.sv
package smc_pkg;

  typedef enum logic [1:0] {
    SGN_ZERO = 2'd0,
    SGN_POS  = 2'd1,
    SGN_NEG  = 2'd2
  } sgn_e;

  function automatic sgn_e sign_of(input logic signed [63:0] v);
    if (v > 64'sd0) return SGN_POS;
    if (v < 64'sd0) return SGN_NEG;
    return SGN_ZERO;
  endfunction

endpackage

// File: rtl/smc_state.sv
module smc_state #(
  parameter int ERR_W = 12,
  parameter int INT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    stb,
  input  logic signed [ERR_W-1:0] err,
  output logic signed [INT_W-1:0] x1,
  output logic signed [INT_W-1:0] x2,
  output logic signed [INT_W-1:0] x3,
  output logic                    vld
);
  typedef logic signed [INT_W:0]   wide_t;
  typedef logic signed [INT_W-1:0] st_t;
  typedef logic signed [ERR_W:0]   dif_t;

  localparam wide_t IMAX = wide_t'({2'b00, {(INT_W-1){1'b1}}});
  localparam wide_t IMIN = wide_t'({2'b11, {(INT_W-1){1'b0}}});

  logic signed [ERR_W-1:0] prev_q;

  function automatic st_t sat_acc(input st_t acc, input logic signed [ERR_W-1:0] e);
    wide_t s;
    s = wide_t'(acc) + wide_t'(e);
    if (s > IMAX) return st_t'(IMAX[INT_W-1:0]);
    if (s < IMIN) return st_t'(IMIN[INT_W-1:0]);
    return st_t'(s[INT_W-1:0]);
  endfunction

  function automatic dif_t delta(input logic signed [ERR_W-1:0] a,
                                 input logic signed [ERR_W-1:0] b);
    return dif_t'(a) - dif_t'(b);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x1     <= '0;
      x2     <= '0;
      x3     <= '0;
      prev_q <= '0;
      vld    <= 1'b0;
    end else begin
      vld <= stb;
      if (stb) begin
        x1     <= st_t'(err);
        x2     <= sat_acc(x2, err);
        x3     <= st_t'(delta(err, prev_q));
        prev_q <= err;
      end
    end
  end

  AST_SUM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(stb) |-> $stable(x2)); // R3

endmodule

// File: rtl/smc_surface.sv
module smc_surface #(
  parameter  int ST_W   = 16,
  parameter  int GAIN_W = 16,
  localparam int SURF_W = ST_W + GAIN_W + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     vld_in,
  input  logic signed [ST_W-1:0]   x1,
  input  logic signed [ST_W-1:0]   x2,
  input  logic signed [ST_W-1:0]   x3,
  input  logic signed [GAIN_W-1:0] g1,
  input  logic signed [GAIN_W-1:0] g2,
  input  logic signed [GAIN_W-1:0] g3,
  output logic signed [SURF_W-1:0] surf,
  output logic                     vld
);
  localparam int PROD_W = ST_W + GAIN_W;
  localparam int NTERM  = 3;

  typedef logic signed [PROD_W-1:0] prod_t;
  typedef logic signed [SURF_W-1:0] sum_t;

  logic signed [ST_W-1:0]   xs   [NTERM];
  logic signed [GAIN_W-1:0] gs   [NTERM];
  prod_t                    term [NTERM];

  assign xs[0] = x1;
  assign xs[1] = x2;
  assign xs[2] = x3;
  assign gs[0] = g1;
  assign gs[1] = g2;
  assign gs[2] = g3;

  for (genvar i = 0; i < NTERM; i++) begin : g_term
    assign term[i] = prod_t'(xs[i]) * prod_t'(gs[i]);
  end

  function automatic sum_t add3(input prod_t a, input prod_t b, input prod_t c);
    return sum_t'(a) + sum_t'(b) + sum_t'(c);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      surf <= '0;
      vld  <= 1'b0;
    end else begin
      vld <= vld_in;
      if (vld_in) surf <= add3(term[0], term[1], term[2]);
    end
  end

  AST_SURF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(vld_in) |-> $stable(surf)); // R5

endmodule

// File: rtl/smc_duty.sv
module smc_duty
  import smc_pkg::*;
#(
  parameter int SURF_W = 34,
  parameter int DUTY_W = 8,
  parameter int SH_W   = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     vld_in,
  input  logic signed [SURF_W-1:0] surf,
  input  logic [SH_W-1:0]          sh,
  input  logic [DUTY_W-1:0]        dmin,
  input  logic [DUTY_W-1:0]        dmax,
  input  logic [DUTY_W-1:0]        dinit,
  output logic [DUTY_W-1:0]        duty,
  output logic                     done
);
  typedef logic signed [SURF_W:0]   dw_t;
  typedef logic signed [SURF_W-1:0] s_t;
  typedef logic [DUTY_W-1:0]        d_t;

  function automatic d_t next_duty(input d_t d, input s_t s, input logic [SH_W-1:0] k,
                                   input d_t lo, input d_t hi);
    s_t  step;
    dw_t t;
    step = s >>> k;
    t    = dw_t'({1'b0, d}) + dw_t'(step);
    if (t < dw_t'({1'b0, lo})) t = dw_t'({1'b0, lo});
    if (t > dw_t'({1'b0, hi})) t = dw_t'({1'b0, hi});
    return t[DUTY_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      duty <= dinit;
      done <= 1'b0;
    end else begin
      done <= vld_in;
      if (vld_in) duty <= next_duty(duty, surf, sh, dmin, dmax);
    end
  end

  AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(duty)); // R8

  AST_DUTY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (done && dmin <= dmax && $stable(dmin) && $stable(dmax))
    |-> (duty >= dmin && duty <= dmax)); // R7

  AST_DIR_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (done && sign_of(64'($past(surf))) == SGN_POS && $stable(dmin) && $stable(dmax)
     && $past(duty) >= dmin && $past(duty) <= dmax)
    |-> duty >= $past(duty)); // R6

  AST_DIR_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && sign_of(64'($past(surf))) == SGN_NEG && $stable(dmin) && $stable(dmax)
     && $past(duty) >= dmin && $past(duty) <= dmax)
    |-> duty <= $past(duty)); // R6

endmodule

// File: rtl/smc_pwm.sv
module smc_pwm #(
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DUTY_W-1:0] duty,
  input  logic [DUTY_W-1:0] dinit,
  output logic [DUTY_W-1:0] cmp,
  output logic              gate
);
  localparam logic [DUTY_W-1:0] CNT_MAX = {DUTY_W{1'b1}};

  logic [DUTY_W-1:0] cnt;
  logic              wrap;

  assign wrap = (cnt == CNT_MAX);
  assign gate = (cnt < cmp);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      cmp <= dinit;
    end else begin
      cnt <= cnt + 1'b1;
      if (wrap) cmp <= duty;
    end
  end

  AST_CMP_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmp) |-> $past(wrap)); // R11

endmodule

// File: rtl/smc_duty_ctrl.sv
module smc_duty_ctrl #(
  parameter  int ERR_W  = 12,
  parameter  int INT_W  = 16,
  parameter  int GAIN_W = 16,
  parameter  int DUTY_W = 8,
  parameter  int SH_W   = 5,
  localparam int SURF_W = INT_W + GAIN_W + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sample_stb,
  input  logic signed [ERR_W-1:0]  err_in,
  input  logic signed [GAIN_W-1:0] gain_p,
  input  logic signed [GAIN_W-1:0] gain_i,
  input  logic signed [GAIN_W-1:0] gain_d,
  input  logic [SH_W-1:0]          shift_amt,
  input  logic [DUTY_W-1:0]        duty_min,
  input  logic [DUTY_W-1:0]        duty_max,
  input  logic [DUTY_W-1:0]        duty_init,
  output logic [DUTY_W-1:0]        duty,
  output logic [DUTY_W-1:0]        pwm_cmp,
  output logic                     gate_hi,
  output logic                     done,
  output logic signed [SURF_W-1:0] surf
);
  logic signed [INT_W-1:0] st_x1, st_x2, st_x3;
  logic                    st_vld;
  logic                    sf_vld;

  smc_state #(.ERR_W(ERR_W), .INT_W(INT_W)) u_state (
    .clk(clk), .rst_n(rst_n), .stb(sample_stb), .err(err_in),
    .x1(st_x1), .x2(st_x2), .x3(st_x3), .vld(st_vld)
  );

  smc_surface #(.ST_W(INT_W), .GAIN_W(GAIN_W)) u_surface (
    .clk(clk), .rst_n(rst_n), .vld_in(st_vld),
    .x1(st_x1), .x2(st_x2), .x3(st_x3),
    .g1(gain_p), .g2(gain_i), .g3(gain_d),
    .surf(surf), .vld(sf_vld)
  );

  smc_duty #(.SURF_W(SURF_W), .DUTY_W(DUTY_W), .SH_W(SH_W)) u_duty (
    .clk(clk), .rst_n(rst_n), .vld_in(sf_vld), .surf(surf), .sh(shift_amt),
    .dmin(duty_min), .dmax(duty_max), .dinit(duty_init),
    .duty(duty), .done(done)
  );

  smc_pwm #(.DUTY_W(DUTY_W)) u_pwm (
    .clk(clk), .rst_n(rst_n), .duty(duty), .dinit(duty_init),
    .cmp(pwm_cmp), .gate(gate_hi)
  );

  AST_STB_TO_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> st_vld); // R9

  AST_STATE_TO_SURF: assert property (@(posedge clk) disable iff (!rst_n)
    st_vld |=> sf_vld); // R8

  AST_SURF_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    sf_vld |=> done); // R8

endmodule

// File: tb/smc_duty_ctrl_test.sv
module smc_duty_ctrl_test;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               sample_stb = 1'b0;
  logic signed [11:0] err_in = '0;
  logic signed [15:0] kp = '0, ki = '0, kd = '0;
  logic [4:0]         sh = 5'd8;
  logic [7:0]         dmin = 8'd0, dmax = 8'd255, dinit = 8'd64;
  logic [7:0]         duty, pwm_cmp;
  logic               gate_hi, done;
  logic signed [33:0] surf;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] pc = '0;
  longint m_x2, m_prev, m_s, m_duty;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) pc <= '0;
    else        pc <= pc + 8'd1;
  end

  smc_duty_ctrl uut (
    .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .err_in(err_in),
    .gain_p(kp), .gain_i(ki), .gain_d(kd), .shift_amt(sh),
    .duty_min(dmin), .duty_max(dmax), .duty_init(dinit),
    .duty(duty), .pwm_cmp(pwm_cmp), .gate_hi(gate_hi), .done(done), .surf(surf)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint sat16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic model_step(input longint e);
    longint x3, t;
    m_x2   = sat16(m_x2 + e);
    x3     = e - m_prev;
    m_prev = e;
    m_s    = longint'(kp) * e + longint'(ki) * m_x2 + longint'(kd) * x3;
    t      = m_duty + (m_s >>> sh);
    if (t < longint'(dmin)) t = longint'(dmin);
    if (t > longint'(dmax)) t = longint'(dmax);
    m_duty = t;
  endtask

  task automatic apply_reset(input logic [7:0] init);
    @(negedge clk);
    rst_n = 1'b0;
    sample_stb = 1'b0;
    dinit = init;
    repeat (3) @(negedge clk);
    rst_n  = 1'b1;
    m_x2   = 0;
    m_prev = 0;
    m_duty = longint'(init);
  endtask

  task automatic do_sample(input longint e, input string req);
    @(negedge clk);
    sample_stb = 1'b1;
    err_in = 12'(e);
    @(negedge clk);
    sample_stb = 1'b0;
    chk("R8", "done after one edge", longint'(done), 0);
    @(negedge clk);
    chk("R8", "done after two edges", longint'(done), 0);
    @(negedge clk);
    model_step(e);
    chk("R8", "done after three edges", longint'(done), 1);
    chk("R5", "surface value", longint'(surf), m_s);
    chk(req, "duty word", longint'(duty), m_duty);
    @(negedge clk);
    chk("R8", "done pulse width", longint'(done), 0);
  endtask

  task automatic set_loop(input int p, input int i, input int d, input int s,
                          input int lo, input int hi);
    kp = 16'(p); ki = 16'(i); kd = 16'(d); sh = 5'(s);
    dmin = 8'(lo); dmax = 8'(hi);
  endtask

  task automatic t_reset;
    apply_reset(8'd64);
    chk("R1", "duty after reset", longint'(duty), 64);
    chk("R1", "compare after reset", longint'(pwm_cmp), 64);
    chk("R1", "done after reset", longint'(done), 0);
    chk("R1", "surface after reset", longint'(surf), 0);
    apply_reset(8'd32);
    chk("R1", "duty reloads new init", longint'(duty), 32);
    chk("R1", "compare reloads new init", longint'(pwm_cmp), 32);
  endtask

  task automatic t_zero_and_prop;
    set_loop(256, 0, 0, 8, 0, 255);
    apply_reset(8'd64);
    do_sample(0, "R2");
    chk("R2", "zero error keeps duty", longint'(duty), 64);
    chk("R2", "zero error zero surface", longint'(surf), 0);
    do_sample(40, "R6");
    chk("R6", "positive error raises duty", longint'(duty), 104);
    do_sample(-25, "R6");
    chk("R6", "negative error lowers duty", longint'(duty), 79);
  endtask

  task automatic t_diff;
    set_loop(0, 0, 256, 8, 0, 255);
    apply_reset(8'd64);
    do_sample(10, "R4");
    chk("R4", "first difference vs cleared history", longint'(surf), 2560);
    do_sample(30, "R4");
    chk("R4", "difference of consecutive errors", longint'(surf), 5120);
    do_sample(30, "R4");
    chk("R4", "equal errors give zero difference", longint'(surf), 0);
  endtask

  task automatic t_integ;
    set_loop(0, 256, 0, 20, 0, 255);
    apply_reset(8'd64);
    for (int i = 0; i < 20; i++) do_sample(2047, "R3");
    chk("R3", "sum saturates high", longint'(surf), 256 * 32767);
    for (int i = 0; i < 40; i++) do_sample(-2048, "R3");
    chk("R3", "sum saturates low", longint'(surf), -256 * 32768);
    do_sample(5, "R3");
    chk("R3", "sum leaves low limit", longint'(surf), -256 * 32763);
  endtask

  task automatic t_clamp;
    set_loop(256, 0, 0, 0, 16, 200);
    apply_reset(8'd64);
    do_sample(2000, "R7");
    chk("R7", "upper clamp", longint'(duty), 200);
    do_sample(-2000, "R7");
    chk("R7", "lower clamp", longint'(duty), 16);
    set_loop(256, 0, 0, 0, 150, 100);
    do_sample(0, "R7");
    chk("R7", "crossed limits give upper", longint'(duty), 100);
  endtask

  task automatic t_burst;
    int pulses;
    set_loop(256, 0, 128, 8, 0, 255);
    apply_reset(8'd64);
    @(negedge clk);
    sample_stb = 1'b1; err_in = 12'sd8;
    @(negedge clk);
    err_in = -12'sd3;
    @(negedge clk);
    err_in = 12'sd12;
    @(negedge clk);
    sample_stb = 1'b0;
    model_step(8);
    model_step(-3);
    model_step(12);
    pulses = 0;
    for (int i = 0; i < 6; i++) begin
      if (i > 0) @(negedge clk);
      if (done) pulses++;
    end
    chk("R9", "one done per back-to-back strobe", longint'(pulses), 3);
    chk("R9", "duty after burst", longint'(duty), m_duty);
    chk("R9", "surface after burst", longint'(surf), m_s);
  endtask

  task automatic t_pwm;
    int highs;
    set_loop(256, 0, 0, 8, 0, 255);
    apply_reset(8'd64);
    while (pc != 8'd10) @(negedge clk);
    do_sample(20, "R6");
    chk("R11", "compare unchanged mid-period", longint'(pwm_cmp), 64);
    while (pc != 8'd255) @(negedge clk);
    chk("R11", "compare unchanged in wrap cycle", longint'(pwm_cmp), 64);
    @(negedge clk);
    chk("R11", "compare loaded after wrap", longint'(pwm_cmp), 84);
    highs = 0;
    for (int i = 0; i < 256; i++) begin
      if (gate_hi) highs++;
      @(negedge clk);
    end
    chk("R10", "gate high cycles per period", longint'(highs), 84);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++;
    n_err++;
    $display("FAIL R8 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    t_reset();
    t_zero_and_prop();
    t_diff();
    t_integ();
    t_clamp();
    t_burst();
    t_pwm();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule